// File: doc/BRIEF.md
# Pixel-Clock Activity Detector and Link State Controller

This block decides, from a free-running reference clock, whether the pixel clock arriving from a display controller is actually toggling, and uses that decision to move a serial display link between three states: shutdown, standby and active. The pixel-clock domain only flips a single toggle flop on every rising edge. That flop is brought into the reference domain through a synchronizer chain, and the reference domain counts the observed changes inside fixed-length windows.

A hysteresis qualifier turns the per-window verdicts into a single "clock running" level. A state machine combines that level with a link-enable input and a test-mode input. The serial lane drivers are modelled as one output-enable. It is raised only in the active state, and only after a fixed settle time. When the pixel clock stops, the link falls back to standby by itself. When the clock resumes, the link returns to active by itself, with no register access.

Top module: `pixclk_link_seq`

## Requirements
- R1: An asserted (low) `rst_n` forces `link_state` to shutdown and `lane_oe` low immediately, without waiting for a reference clock edge.
- R2: While `link_en` is low, the block is in shutdown with `lane_oe` low, whatever the pixel clock is doing (reached within 3 reference cycles of `link_en` falling). Activity history is discarded, so re-enabling with a running clock first gives standby.
- R3: With `link_en` high and no pixel clock, the block sits in standby with `lane_oe` low.
- R4: A window of `WIN_CYCLES` reference cycles counts as busy only if at least `MIN_EDGES` pixel-clock rising edges were observed in it. A clock that gives at most one edge per window (default parameters) never leads to active.
- R5: Active is entered from standby only after `ON_WINDOWS` (default 4) consecutive busy windows. Shutdown never leads straight to active.
- R6: Active falls back to standby only after `OFF_WINDOWS` (default 2) consecutive idle windows. A pause shorter than one window keeps the link active with `lane_oe` high throughout.
- R7: `lane_oe` is high only in active. It rises exactly `SETTLE_CYCLES` (default 16) reference cycles after `link_state` first reads active, and it drops in the same cycle the state leaves active.
- R8: While `test_mode` is high the block never reaches active, and an active link drops to standby. When `test_mode` returns low with the pixel clock still qualified as running, the block goes back to active directly, and the settle delay restarts.
- R9: `link_state` encodes 2'b00 = shutdown, 2'b01 = standby, 2'b10 = active. The code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; all control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pix_clk | input | 1 | Incoming pixel clock whose activity is monitored; may stop at any time |
| link_en | input | 1 | Active-high link enable; low selects shutdown |
| test_mode | input | 1 | Must be low for normal operation; high keeps the link out of active |
| lane_oe | output | 1 | Output-enable for the serial lane drivers (low = high impedance) |
| link_state | output | 2 | Link state for the serializer: 00 shutdown, 01 standby, 10 active |

## Verification
The bench runs a pixel clock that is too slow to qualify, and checks that standby holds. A detector that counted any single edge as activity would wrongly go active. It samples standby just before the earliest legal fourth busy window and active well after it, which catches a qualifier that enters active a window early. It stops the clock for less than one window and checks that `lane_oe` never falls, which catches a design that drops on the first idle window. The bench also measures the exact settle delay on every entry to active, including the entry after a test-mode release, and re-enables the link with the clock still running to catch activity history that survives shutdown.

// File: rtl/pls_pkg.sv
`timescale 1ns/1ps
package pls_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'b00,
    ST_STANDBY = 2'b01,
    ST_ACTIVE  = 2'b10
  } link_st_e;
endpackage

// File: rtl/pls_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer; also used as a reset synchronizer (d tied high).
module pls_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/pls_edge_probe.sv
`timescale 1ns/1ps
// Pixel-domain toggle flop carried into the reference domain; one pulse per
// observed pixel-clock rising edge.
module pls_edge_probe #(
  parameter int SYNC_STAGES = 2
) (
  input  logic pix_clk,
  input  logic pix_rst_n,
  input  logic ref_clk,
  input  logic ref_rst_n,
  output logic edge_seen
);
  logic tog_q;
  logic tog_s;
  logic tog_d_q;

  always_ff @(posedge pix_clk or negedge pix_rst_n) begin
    if (!pix_rst_n) tog_q <= 1'b0;
    else            tog_q <= ~tog_q;
  end

  pls_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tog_sync (
    .clk   (ref_clk),
    .rst_n (ref_rst_n),
    .d     (tog_q),
    .q     (tog_s)
  );

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) tog_d_q <= 1'b0;
    else            tog_d_q <= tog_s;
  end

  assign edge_seen = tog_s ^ tog_d_q;
endmodule

// File: rtl/pls_window.sv
`timescale 1ns/1ps
// Fixed reference window; reports at its last cycle whether enough edges fell in it.
module pls_window #(
  parameter int WIN_CYCLES = 32,
  parameter int MIN_EDGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic edge_seen,
  output logic win_end,
  output logic win_busy
);
  localparam int CW = $clog2(WIN_CYCLES);
  localparam int EW = $clog2(MIN_EDGES + 1);
  localparam logic [CW-1:0] CYC_LAST = CW'(WIN_CYCLES - 1);
  localparam logic [EW-1:0] EDG_SAT  = EW'(MIN_EDGES);

  logic [CW-1:0] cyc_q, cyc_nxt;
  logic [EW-1:0] edg_q, edg_nxt;

  assign win_end  = (cyc_q == CYC_LAST);
  assign win_busy = (edg_q >= EDG_SAT);

  always_comb begin
    cyc_nxt = cyc_q;
    edg_nxt = edg_q;
    if (clr) begin
      cyc_nxt = '0;
      edg_nxt = '0;
    end else if (win_end) begin
      cyc_nxt = '0;
      edg_nxt = EW'(edge_seen);
    end else begin
      cyc_nxt = cyc_q + 1'b1;
      if (edge_seen && (edg_q < EDG_SAT)) edg_nxt = edg_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      edg_q <= '0;
    end else begin
      cyc_q <= cyc_nxt;
      edg_q <= edg_nxt;
    end
  end
endmodule

// File: rtl/pls_qualify.sv
`timescale 1ns/1ps
// Hysteresis on window verdicts: N busy windows in a row to start, M idle to stop.
module pls_qualify #(
  parameter int ON_WINDOWS  = 4,
  parameter int OFF_WINDOWS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic win_end,
  input  logic win_busy,
  output logic running
);
  localparam int BW = $clog2(ON_WINDOWS + 1);
  localparam int IW = $clog2(OFF_WINDOWS + 1);
  localparam logic [BW-1:0] BUSY_MAX = BW'(ON_WINDOWS);
  localparam logic [IW-1:0] IDLE_MAX = IW'(OFF_WINDOWS);
  localparam logic [BW-1:0] BUSY_TRIP = BW'(ON_WINDOWS - 1);
  localparam logic [IW-1:0] IDLE_TRIP = IW'(OFF_WINDOWS - 1);

  logic [BW-1:0] busy_q, busy_nxt;
  logic [IW-1:0] idle_q, idle_nxt;
  logic          run_q, run_nxt;
  logic          upd_en;

  assign upd_en = clr | win_end;

  always_comb begin
    busy_nxt = busy_q;
    idle_nxt = idle_q;
    run_nxt  = run_q;
    if (clr) begin
      busy_nxt = '0;
      idle_nxt = '0;
      run_nxt  = 1'b0;
    end else if (win_busy) begin
      idle_nxt = '0;
      if (busy_q != BUSY_MAX) busy_nxt = busy_q + 1'b1;
      if (busy_q >= BUSY_TRIP) run_nxt = 1'b1;
    end else begin
      busy_nxt = '0;
      if (idle_q != IDLE_MAX) idle_nxt = idle_q + 1'b1;
      if (idle_q >= IDLE_TRIP) run_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      idle_q <= '0;
      run_q  <= 1'b0;
    end else if (upd_en) begin
      busy_q <= busy_nxt;
      idle_q <= idle_nxt;
      run_q  <= run_nxt;
    end
  end

  assign running = run_q;
endmodule

// File: rtl/pls_fsm.sv
`timescale 1ns/1ps
// Link state machine with settle counter for the lane output-enable.
module pls_fsm
  import pls_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     tm,
  input  logic     running,
  output link_st_e state,
  output logic     lane_oe
);
  localparam int SW = $clog2(SETTLE_CYCLES);
  localparam logic [SW-1:0] CNT_LAST = SW'(SETTLE_CYCLES - 1);

  link_st_e      state_q, state_nxt;
  logic [SW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;
  logic          oe_q, oe_nxt;

  always_comb begin
    state_nxt = state_q;
    if (!en) begin
      state_nxt = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:     state_nxt = ST_STANDBY;
        ST_STANDBY: if (running && !tm) state_nxt = ST_ACTIVE;
        ST_ACTIVE:  if (!running || tm) state_nxt = ST_STANDBY;
        default:    state_nxt = ST_OFF;
      endcase
    end
  end

  always_comb begin
    cnt_en  = 1'b0;
    cnt_nxt = cnt_q;
    if (state_q != ST_ACTIVE) begin
      cnt_en  = (cnt_q != '0);
      cnt_nxt = '0;
    end else if (cnt_q != CNT_LAST) begin
      cnt_en  = 1'b1;
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  assign oe_nxt = (state_nxt == ST_ACTIVE) &&
                  (oe_q || ((state_q == ST_ACTIVE) && (cnt_q == CNT_LAST)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_nxt;
      oe_q    <= oe_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  assign state   = state_q;
  assign lane_oe = oe_q;
endmodule

// File: rtl/pixclk_link_seq.sv
`timescale 1ns/1ps
module pixclk_link_seq
  import pls_pkg::*;
#(
  parameter int WIN_CYCLES    = 32,
  parameter int MIN_EDGES     = 2,
  parameter int ON_WINDOWS    = 4,
  parameter int OFF_WINDOWS   = 2,
  parameter int SETTLE_CYCLES = 16,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       pix_clk,
  input  logic       link_en,
  input  logic       test_mode,
  output logic       lane_oe,
  output logic [1:0] link_state
);
  logic       rst_ref_n;
  logic [1:0] ctrl_s;
  logic       en_s;
  logic       tm_s;
  logic       edge_seen;
  logic       win_end;
  logic       win_busy;
  logic       running;
  logic       hist_clr;
  link_st_e   st;

  pls_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_ref_n)
  );

  pls_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_ctrl_sync (
    .clk   (ref_clk),
    .rst_n (rst_ref_n),
    .d     ({test_mode, link_en}),
    .q     (ctrl_s)
  );

  assign en_s     = ctrl_s[0];
  assign tm_s     = ctrl_s[1];
  assign hist_clr = ~en_s;

  pls_edge_probe #(.SYNC_STAGES(SYNC_STAGES)) u_probe (
    .pix_clk   (pix_clk),
    .pix_rst_n (rst_n),
    .ref_clk   (ref_clk),
    .ref_rst_n (rst_ref_n),
    .edge_seen (edge_seen)
  );

  pls_window #(.WIN_CYCLES(WIN_CYCLES), .MIN_EDGES(MIN_EDGES)) u_window (
    .clk       (ref_clk),
    .rst_n     (rst_ref_n),
    .clr       (hist_clr),
    .edge_seen (edge_seen),
    .win_end   (win_end),
    .win_busy  (win_busy)
  );

  pls_qualify #(.ON_WINDOWS(ON_WINDOWS), .OFF_WINDOWS(OFF_WINDOWS)) u_qual (
    .clk      (ref_clk),
    .rst_n    (rst_ref_n),
    .clr      (hist_clr),
    .win_end  (win_end),
    .win_busy (win_busy),
    .running  (running)
  );

  pls_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk     (ref_clk),
    .rst_n   (rst_ref_n),
    .en      (en_s),
    .tm      (tm_s),
    .running (running),
    .state   (st),
    .lane_oe (lane_oe)
  );

  assign link_state = st;
endmodule

// File: rtl/pixclk_link_seq_chk.sv
`timescale 1ns/1ps
module pixclk_link_seq_chk #(
  parameter int SETTLE_CYCLES = 16
) (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       link_en,
  input logic       test_mode,
  input logic       lane_oe,
  input logic [1:0] link_state
);
  localparam int AW = $clog2(SETTLE_CYCLES + 1) + 1;
  localparam logic [AW-1:0] A_MAX = {AW{1'b1}};

  logic [AW-1:0] act_cnt;

  // Cycles spent in active, counted independently of the design's counter.
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                     act_cnt <= '0;
    else if (link_state != 2'b10)   act_cnt <= '0;
    else if (act_cnt != A_MAX)      act_cnt <= act_cnt + 1'b1;
  end

  assert_legal_code_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    link_state != 2'b11);

  assert_oe_after_settle_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    lane_oe |-> (link_state == 2'b10) && (act_cnt >= AW'(SETTLE_CYCLES)));

  assert_oe_rise_exact_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lane_oe) |-> (act_cnt == AW'(SETTLE_CYCLES)));

  assert_disable_shutdown_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!link_en && $past(!link_en) && $past(!link_en, 2)) |=> (link_state == 2'b00) && !lane_oe);

  assert_testmode_blocks_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (test_mode && $past(test_mode) && $past(test_mode, 2)) |=> (link_state != 2'b10));

  assert_no_direct_entry_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (link_state == 2'b00) |=> (link_state != 2'b10));
endmodule

bind pixclk_link_seq pixclk_link_seq_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
  .ref_clk    (ref_clk),
  .rst_n      (rst_n),
  .link_en    (link_en),
  .test_mode  (test_mode),
  .lane_oe    (lane_oe),
  .link_state (link_state)
);

// File: tb/pixclk_link_seq_tb.sv
`timescale 1ns/1ps
module pixclk_link_seq_tb;
  localparam int W      = 32;
  localparam int SETTLE = 16;
  localparam logic [1:0] S_OFF = 2'b00, S_SBY = 2'b01, S_ACT = 2'b10;

  typedef struct {
    int         kind;   // 0 level, 1 settle length, 2 oe fall count, 3 illegal code count
    logic [1:0] st;
    logic       oe;
    int         val;
    string      tag;
  } item_t;

  logic       ref_clk = 1'b0;
  logic       rst_n;
  logic       pix_clk = 1'b0;
  logic       link_en;
  logic       test_mode;
  logic       lane_oe;
  logic [1:0] link_state;

  bit  pix_run  = 1'b0;
  int  pix_half = 40;
  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;
  int  last_settle = -1;
  int  oe_falls = 0;
  int  illegal = 0;
  item_t sb_q[$];

  pixclk_link_seq u_dut (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .pix_clk    (pix_clk),
    .link_en    (link_en),
    .test_mode  (test_mode),
    .lane_oe    (lane_oe),
    .link_state (link_state)
  );

  always #10 ref_clk = ~ref_clk;

  initial begin
    forever begin
      if (pix_run) begin
        #(pix_half) pix_clk = ~pix_clk;
      end else begin
        pix_clk = 1'b0;
        #10;
      end
    end
  end

  // Observers: settle length on each active entry, oe falls, illegal codes.
  initial begin
    logic [1:0] prev_st = 2'b00;
    logic       prev_oe = 1'b0;
    int         run_cnt = 0;
    bit         timing  = 1'b0;
    forever begin
      @(negedge ref_clk);
      if (link_state == 2'b11) illegal++;
      if (prev_oe && !lane_oe) oe_falls++;
      if (link_state == S_ACT && prev_st != S_ACT) begin
        run_cnt = 0;
        timing  = 1'b1;
      end else if (link_state == S_ACT && timing) begin
        run_cnt++;
        if (lane_oe) begin
          last_settle = run_cnt;
          timing = 1'b0;
        end
      end
      if (link_state != S_ACT) timing = 1'b0;
      prev_st = link_state;
      prev_oe = lane_oe;
    end
  end

  // Scoreboard monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge ref_clk);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        total++;
        case (it.kind)
          0: if (link_state !== it.st || lane_oe !== it.oe) begin
               bad++;
               $display("FAIL %s: state=%b oe=%b expected state=%b oe=%b",
                        it.tag, link_state, lane_oe, it.st, it.oe);
             end
          1: begin
               if (last_settle != it.val) begin
                 bad++;
                 $display("FAIL %s: settle=%0d expected %0d", it.tag, last_settle, it.val);
               end
               last_settle = -1;
             end
          2: if (oe_falls != it.val) begin
               bad++;
               $display("FAIL %s: oe falls=%0d expected %0d", it.tag, oe_falls, it.val);
             end
          default: if (illegal != it.val) begin
               bad++;
               $display("FAIL %s: illegal codes=%0d expected %0d", it.tag, illegal, it.val);
             end
        endcase
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
    #1;
  endtask

  task automatic push(input int kind, input logic [1:0] st, input logic oe,
                      input int val, input string tag);
    item_t it;
    it.kind = kind; it.st = st; it.oe = oe; it.val = val; it.tag = tag;
    sb_q.push_back(it);
    cyc(1);
  endtask

  task automatic expect_lvl(input logic [1:0] st, input logic oe, input string tag);
    push(0, st, oe, 0, tag);
  endtask

  initial begin
    int falls_snap;
    rst_n = 1'b0; link_en = 1'b0; test_mode = 1'b0;
    cyc(3);
    expect_lvl(S_OFF, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    cyc(10);
    expect_lvl(S_OFF, 1'b0, "R2 disabled after reset");

    link_en = 1'b1;
    cyc(10);
    expect_lvl(S_SBY, 1'b0, "R3 enabled without pixel clock");
    cyc(6 * W);
    expect_lvl(S_SBY, 1'b0, "R3 standby holds without clock");

    pix_half = 600; pix_run = 1'b1;          // at most one edge per window
    cyc(10 * W);
    expect_lvl(S_SBY, 1'b0, "R4 too-slow clock stays standby");

    pix_run = 1'b0; cyc(W);
    pix_half = 40; pix_run = 1'b1;
    cyc(3 * W - 1);
    expect_lvl(S_SBY, 1'b0, "R5 no active before fourth busy window");
    cyc(3 * W + SETTLE + 10);
    expect_lvl(S_ACT, 1'b1, "R5 active after busy windows");
    push(1, S_ACT, 1'b1, SETTLE, "R7 settle delay on first entry");

    falls_snap = oe_falls;
    pix_run = 1'b0; cyc(20); pix_run = 1'b1;
    cyc(4 * W);
    expect_lvl(S_ACT, 1'b1, "R6 short pause keeps active");
    push(2, S_ACT, 1'b1, falls_snap, "R6 no oe drop during short pause");

    pix_run = 1'b0;
    cyc(40);
    expect_lvl(S_ACT, 1'b1, "R6 one idle window does not drop");
    cyc(3 * W);
    expect_lvl(S_SBY, 1'b0, "R6 standby after idle windows");

    pix_run = 1'b1;
    cyc(6 * W + SETTLE + 10);
    expect_lvl(S_ACT, 1'b1, "R5 clock restart returns to active");
    test_mode = 1'b1;
    cyc(5);
    expect_lvl(S_SBY, 1'b0, "R8 test mode leaves active");
    cyc(3 * W);
    expect_lvl(S_SBY, 1'b0, "R8 test mode holds standby");
    test_mode = 1'b0;
    cyc(5);
    expect_lvl(S_ACT, 1'b0, "R8 release returns to active, oe pending");
    cyc(SETTLE + 5);
    push(1, S_ACT, 1'b1, SETTLE, "R7 settle restarts after test mode");
    expect_lvl(S_ACT, 1'b1, "R7 oe high after settle");

    link_en = 1'b0;
    cyc(5);
    expect_lvl(S_OFF, 1'b0, "R2 disable with running clock");
    cyc(4 * W);
    expect_lvl(S_OFF, 1'b0, "R2 shutdown holds with running clock");
    link_en = 1'b1;
    cyc(5);
    expect_lvl(S_SBY, 1'b0, "R2 history discarded on re-enable");
    cyc(3 * W - 10);
    expect_lvl(S_SBY, 1'b0, "R5 re-qualification needed");
    cyc(3 * W + SETTLE + 10);
    expect_lvl(S_ACT, 1'b1, "R5 active again after re-enable");

    #3 rst_n = 1'b0;
    cyc(0);
    expect_lvl(S_OFF, 1'b0, "R1 async reset from active");
    rst_n = 1'b1;
    cyc(5);
    push(3, S_OFF, 1'b0, 0, "R9 no illegal state code");

    cyc(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge ref_clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (every requirement): actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule